// File: doc/BRIEF.md
# MDIO Management Slave with Burst Register Access

This block is the serial side of a PHY management port. It is clocked by the management clock MDC. It watches the bidirectional data line through a split input/output pair. After it has seen an idle line, it decodes a management frame, checks that the frame is addressed to its own PHY address strap, and then either fetches a 16-bit word from an external register file and shifts it out, or shifts a word in and presents it to the register file with a one-cycle write strobe. The register storage itself lives outside the block, behind a simple address / read-data / write-data / write-enable port.

A reserved register address, all ones, selects a burst. When the burst enable input is high, one frame with that address carries every implemented register. There are eleven of them, at addresses 0 to 5 and 16 to 20, and they are visited in ascending order. The data phase grows from 16 to 176 MDC edges, so the whole frame lasts 192 edges. When the burst enable input is low, the reserved address behaves as an empty register.

After any frame, the block is deaf until it has again counted 32 consecutive ones on the line. Only then can a start pattern open the next frame.

Top module: `mdio_burst_slave`

## Requirements
- R1: Coming out of reset, `mdio_oe` and `rf_we` are low, and the slave does not respond until 32 consecutive ones have been sampled.
- R2: A frame whose start bit follows fewer than 32 consecutive ones is ignored: no drive on the line and no write strobe.
- R3: A frame is acted on only when its first two bits are 0 then 1, its opcode is 10 (read) or 01 (write), and its 5-bit PHY field, sent MSB first, equals `phy_addr`. Otherwise no drive and no write strobe result.
- R4: A read drives the line from the second turnaround bit on: that bit is 0. It is followed by the 16-bit word from `rf_rdata` at the addressed register, MSB first. The 5-bit register field follows the PHY field, MSB first.
- R5: A write takes the 16 bits after the two turnaround bits, MSB first. It raises `rf_we` for exactly one MDC cycle, on the edge that samples the last data bit, with the frame's register address on `rf_addr` and the word on `rf_wdata`.
- R6: With `burst_en` high, register address 31 makes a burst: eleven 16-bit words for addresses 0,1,2,3,4,5,16,17,18,19,20 in that order, taking 192 MDC edges including the 16-edge header.
- R7: In a burst read, the output enable stays high without a gap from the second turnaround bit through the last data bit and drops on the next edge. A single read holds it for 17 cycles and a burst read for 177.
- R8: A burst write issues eleven write strobes, one per word, with ascending implemented addresses and the matching data.
- R9: With `burst_en` low, a read of address 31 returns sixteen zeros, and a write to address 31 raises no strobe.
- R10: After a frame ends, a new frame is accepted only after another 32 consecutive ones.
- R11: `rf_we` is never high while the slave drives the line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mdc | input | 1 | Management clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously to `mdc` |
| mdio_i | input | 1 | Sampled value of the management data line |
| phy_addr | input | 5 | PHY address strap the frame must match |
| burst_en | input | 1 | Burst enable bit from the configuration register |
| rf_rdata | input | 16 | Register file read data at `rf_addr` |
| mdio_o | output | 1 | Value driven onto the data line while `mdio_oe` is high |
| mdio_oe | output | 1 | Output enable of the data line pad |
| rf_addr | output | 5 | Register file address for the current word |
| rf_we | output | 1 | One-cycle write strobe into the register file |
| rf_wdata | output | 16 | Write word, valid while `rf_we` is high |

## Verification
Some properties are checked by assertions on every cycle. The write strobe never coincides with the line being driven, is never longer than one cycle, and never targets the reserved address. Every drive begins with a zero turnaround bit and lasts exactly 17 or 177 cycles. Other behaviours need the bench's scenarios to show them. These are the idle-count gate before and after frames, PHY and opcode filtering, the word values and their bit order, the burst address sequence, and the empty reserved register when bursts are off.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

  typedef enum logic [1:0] {
    ST_HUNT = 2'd0,
    ST_HDR  = 2'd1,
    ST_RD   = 2'd2,
    ST_WR   = 2'd3
  } mdio_state_e;

  localparam logic [1:0] START_PAT = 2'b01;
  localparam logic [1:0] OP_READ   = 2'b10;
  localparam logic [1:0] OP_WRITE  = 2'b01;

endpackage

// File: rtl/mdio_idle_det.sv
// Counts consecutive ones while the controller is hunting for a frame.
module mdio_idle_det #(
  parameter int IDLE_ONES = 32
) (
  input  logic mdc,
  input  logic rst_n,
  input  logic mdio_i,
  input  logic hunting,
  output logic idle_ok
);

  localparam int CW = $clog2(IDLE_ONES + 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (!hunting || !mdio_i) begin
      cnt_d = '0;
    end else if (cnt_q != CW'(IDLE_ONES)) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge mdc or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign idle_ok = (cnt_q == CW'(IDLE_ONES));

endmodule

// File: rtl/mdio_frame_ctrl.sv
// Frame sequencer: header decode, word slots, burst address walk, write strobe.
module mdio_frame_ctrl
  import mdio_pkg::*;
#(
  parameter int PHY_AW    = 5,
  parameter int REG_AW    = 5,
  parameter int DATA_W    = 16,
  parameter int LOW_LAST  = 5,
  parameter int HIGH_BASE = 16,
  parameter int NUM_WORDS = 11
) (
  input  logic              mdc,
  input  logic              rst_n,
  input  logic              mdio_i,
  input  logic [PHY_AW-1:0] phy_addr,
  input  logic              burst_en,
  input  logic              idle_ok,
  input  logic [DATA_W-1:0] rf_rdata,
  output logic              hunting,
  output logic [REG_AW-1:0] rf_addr,
  output logic              rf_we,
  output logic [DATA_W-1:0] rf_wdata,
  output logic              tx_ta,
  output logic              tx_load,
  output logic [DATA_W-1:0] tx_word,
  output logic              tx_rel
);

  localparam int HDR_BITS = 4 + PHY_AW + REG_AW;
  localparam int HDR_LEN  = HDR_BITS + 2;
  localparam int POS_MAX  = (DATA_W > HDR_LEN) ? DATA_W : HDR_LEN;
  localparam int POS_W    = $clog2(POS_MAX);
  localparam int WRD_W    = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;
  localparam int RX_W     = (DATA_W > HDR_BITS) ? DATA_W - 1 : HDR_BITS - 1;
  localparam logic [REG_AW-1:0] BURST_ADDR = '1;

  mdio_state_e       state_q, state_d;
  logic [POS_W-1:0]  pos_q, pos_d;
  logic [WRD_W-1:0]  word_q, word_d;
  logic [REG_AW-1:0] addr_q, addr_d;
  logic              rd_q, rd_d;
  logic              burst_q, burst_d;
  logic              blank_q, blank_d;
  logic [RX_W-1:0]   rx_q, rx_d;

  logic [HDR_BITS-1:0] hdr;
  logic [1:0]          start_f, op_f;
  logic [PHY_AW-1:0]   phy_f;
  logic [REG_AW-1:0]   reg_f;
  logic                hdr_ok, slot_end, last_word;
  logic [REG_AW-1:0]   addr_nxt;

  assign hdr     = {rx_q[HDR_BITS-2:0], mdio_i};
  assign start_f = hdr[HDR_BITS-1 -: 2];
  assign op_f    = hdr[HDR_BITS-3 -: 2];
  assign phy_f   = hdr[REG_AW +: PHY_AW];
  assign reg_f   = hdr[REG_AW-1:0];
  assign hdr_ok  = (start_f == START_PAT) &&
                   ((op_f == OP_READ) || (op_f == OP_WRITE)) &&
                   (phy_f == phy_addr);

  assign slot_end  = (pos_q == POS_W'(DATA_W - 1));
  assign last_word = !burst_q || (word_q == WRD_W'(NUM_WORDS - 1));
  assign addr_nxt  = (addr_q == REG_AW'(LOW_LAST)) ? REG_AW'(HIGH_BASE)
                                                   : addr_q + 1'b1;

  always_comb begin
    state_d = state_q;
    pos_d   = pos_q;
    word_d  = word_q;
    addr_d  = addr_q;
    rd_d    = rd_q;
    burst_d = burst_q;
    blank_d = blank_q;
    rx_d    = {rx_q[RX_W-2:0], mdio_i};
    tx_ta   = 1'b0;
    tx_load = 1'b0;
    tx_rel  = 1'b0;
    rf_we   = 1'b0;
    unique case (state_q)
      ST_HUNT: begin
        if (idle_ok && !mdio_i) begin
          state_d = ST_HDR;
          pos_d   = POS_W'(1);
        end
      end
      ST_HDR: begin
        pos_d = pos_q + 1'b1;
        if (pos_q == POS_W'(HDR_BITS - 1)) begin
          if (!hdr_ok) begin
            state_d = ST_HUNT;
          end else begin
            rd_d    = (op_f == OP_READ);
            burst_d = (reg_f == BURST_ADDR) && burst_en;
            blank_d = (reg_f == BURST_ADDR) && !burst_en;
            addr_d  = ((reg_f == BURST_ADDR) && burst_en) ? '0 : reg_f;
          end
        end
        if ((pos_q == POS_W'(HDR_BITS)) && rd_q) begin
          tx_ta = 1'b1;
        end
        if (pos_q == POS_W'(HDR_LEN - 1)) begin
          state_d = rd_q ? ST_RD : ST_WR;
          pos_d   = '0;
          word_d  = '0;
          if (rd_q) begin
            tx_load = 1'b1;
            if (burst_q) addr_d = addr_nxt;
          end
        end
      end
      ST_RD: begin
        pos_d = pos_q + 1'b1;
        if (slot_end) begin
          pos_d = '0;
          if (last_word) begin
            state_d = ST_HUNT;
            tx_rel  = 1'b1;
          end else begin
            word_d  = word_q + 1'b1;
            tx_load = 1'b1;
            if (burst_q) addr_d = addr_nxt;
          end
        end
      end
      ST_WR: begin
        pos_d = pos_q + 1'b1;
        if (slot_end) begin
          pos_d = '0;
          rf_we = !blank_q;
          if (burst_q) addr_d = addr_nxt;
          if (last_word) begin
            state_d = ST_HUNT;
          end else begin
            word_d = word_q + 1'b1;
          end
        end
      end
      default: state_d = ST_HUNT;
    endcase
  end

  always_ff @(posedge mdc or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_HUNT;
      pos_q   <= '0;
      word_q  <= '0;
      addr_q  <= '0;
      rd_q    <= 1'b0;
      burst_q <= 1'b0;
      blank_q <= 1'b0;
      rx_q    <= '0;
    end else begin
      state_q <= state_d;
      pos_q   <= pos_d;
      word_q  <= word_d;
      addr_q  <= addr_d;
      rd_q    <= rd_d;
      burst_q <= burst_d;
      blank_q <= blank_d;
      rx_q    <= rx_d;
    end
  end

  assign hunting  = (state_q == ST_HUNT);
  assign rf_addr  = addr_q;
  assign rf_wdata = {rx_q[DATA_W-2:0], mdio_i};
  assign tx_word  = blank_q ? '0 : rf_rdata;

endmodule

// File: rtl/mdio_tx.sv
// Output side: turnaround zero, word load, MSB-first shift, release.
module mdio_tx #(
  parameter int DATA_W = 16
) (
  input  logic              mdc,
  input  logic              rst_n,
  input  logic              ta,
  input  logic              load,
  input  logic              rel,
  input  logic [DATA_W-1:0] word,
  output logic              mdio_o,
  output logic              mdio_oe
);

  logic              oe_q, oe_d;
  logic              out_q, out_d;
  logic [DATA_W-2:0] sh_q, sh_d;

  always_comb begin
    oe_d  = oe_q;
    out_d = out_q;
    sh_d  = sh_q;
    if (rel) begin
      oe_d  = 1'b0;
      out_d = 1'b0;
    end else if (ta) begin
      oe_d  = 1'b1;
      out_d = 1'b0;
    end else if (load) begin
      out_d = word[DATA_W-1];
      sh_d  = word[DATA_W-2:0];
    end else if (oe_q) begin
      out_d = sh_q[DATA_W-2];
      sh_d  = {sh_q[DATA_W-3:0], 1'b0};
    end
  end

  always_ff @(posedge mdc or negedge rst_n) begin
    if (!rst_n) begin
      oe_q  <= 1'b0;
      out_q <= 1'b0;
      sh_q  <= '0;
    end else begin
      oe_q  <= oe_d;
      out_q <= out_d;
      sh_q  <= sh_d;
    end
  end

  assign mdio_o  = out_q;
  assign mdio_oe = oe_q;

endmodule

// File: rtl/mdio_burst_slave.sv
module mdio_burst_slave
  import mdio_pkg::*;
#(
  parameter int PHY_AW    = 5,
  parameter int REG_AW    = 5,
  parameter int DATA_W    = 16,
  parameter int IDLE_ONES = 32,
  parameter int LOW_LAST  = 5,
  parameter int HIGH_BASE = 16,
  parameter int HIGH_LAST = 20
) (
  input  logic              mdc,
  input  logic              rst_n,
  input  logic              mdio_i,
  input  logic [PHY_AW-1:0] phy_addr,
  input  logic              burst_en,
  input  logic [DATA_W-1:0] rf_rdata,
  output logic              mdio_o,
  output logic              mdio_oe,
  output logic [REG_AW-1:0] rf_addr,
  output logic              rf_we,
  output logic [DATA_W-1:0] rf_wdata
);

  localparam int NUM_WORDS = (LOW_LAST + 1) + (HIGH_LAST - HIGH_BASE + 1);

  logic              hunting, idle_ok;
  logic              tx_ta, tx_load, tx_rel;
  logic [DATA_W-1:0] tx_word;

  mdio_idle_det #(
    .IDLE_ONES(IDLE_ONES)
  ) u_idle (
    .mdc    (mdc),
    .rst_n  (rst_n),
    .mdio_i (mdio_i),
    .hunting(hunting),
    .idle_ok(idle_ok)
  );

  mdio_frame_ctrl #(
    .PHY_AW   (PHY_AW),
    .REG_AW   (REG_AW),
    .DATA_W   (DATA_W),
    .LOW_LAST (LOW_LAST),
    .HIGH_BASE(HIGH_BASE),
    .NUM_WORDS(NUM_WORDS)
  ) u_ctrl (
    .mdc     (mdc),
    .rst_n   (rst_n),
    .mdio_i  (mdio_i),
    .phy_addr(phy_addr),
    .burst_en(burst_en),
    .idle_ok (idle_ok),
    .rf_rdata(rf_rdata),
    .hunting (hunting),
    .rf_addr (rf_addr),
    .rf_we   (rf_we),
    .rf_wdata(rf_wdata),
    .tx_ta   (tx_ta),
    .tx_load (tx_load),
    .tx_word (tx_word),
    .tx_rel  (tx_rel)
  );

  mdio_tx #(
    .DATA_W(DATA_W)
  ) u_tx (
    .mdc    (mdc),
    .rst_n  (rst_n),
    .ta     (tx_ta),
    .load   (tx_load),
    .rel    (tx_rel),
    .word   (tx_word),
    .mdio_o (mdio_o),
    .mdio_oe(mdio_oe)
  );

endmodule

// File: rtl/mdio_burst_slave_chk.sv
module mdio_burst_slave_chk #(
  parameter int DATA_W    = 16,
  parameter int REG_AW    = 5,
  parameter int NUM_WORDS = 11
) (
  input logic              mdc,
  input logic              rst_n,
  input logic              mdio_o,
  input logic              mdio_oe,
  input logic              rf_we,
  input logic [REG_AW-1:0] rf_addr
);

  localparam int SINGLE_LEN = DATA_W + 1;
  localparam int BURST_LEN  = DATA_W * NUM_WORDS + 1;
  localparam int LW         = $clog2(BURST_LEN + 2) + 1;

  logic [LW-1:0] oe_len_q;

  always_ff @(posedge mdc or negedge rst_n) begin
    if (!rst_n) begin
      oe_len_q <= '0;
    end else if (mdio_oe) begin
      oe_len_q <= oe_len_q + 1'b1;
    end else begin
      oe_len_q <= '0;
    end
  end

  // R11: no register write while the line is driven
  assert_we_while_driving_R11: assert property (@(posedge mdc) disable iff (!rst_n)
    rf_we |-> !mdio_oe);

  // R4: the drive always opens with the zero turnaround bit
  assert_ta_zero_R4: assert property (@(posedge mdc) disable iff (!rst_n)
    $rose(mdio_oe) |-> !mdio_o);

  // R5: a write strobe lasts one cycle
  assert_we_one_cycle_R5: assert property (@(posedge mdc) disable iff (!rst_n)
    rf_we |=> !rf_we);

  // R7: drive window is exactly a single or a burst length
  assert_drive_len_R7: assert property (@(posedge mdc) disable iff (!rst_n)
    $fell(mdio_oe) |-> (oe_len_q == LW'(SINGLE_LEN) || oe_len_q == LW'(BURST_LEN)));

  // R9: the reserved address is never written
  assert_no_reserved_write_R9: assert property (@(posedge mdc) disable iff (!rst_n)
    rf_we |-> (rf_addr != '1));

endmodule

bind mdio_burst_slave mdio_burst_slave_chk #(
  .DATA_W   (DATA_W),
  .REG_AW   (REG_AW),
  .NUM_WORDS(NUM_WORDS)
) u_chk (
  .mdc    (mdc),
  .rst_n  (rst_n),
  .mdio_o (mdio_o),
  .mdio_oe(mdio_oe),
  .rf_we  (rf_we),
  .rf_addr(rf_addr)
);

// File: tb/mdio_burst_slave_bench.sv
module mdio_burst_slave_bench;

  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 150000;
  localparam logic [4:0] MY_PHY = 5'h0B;
  localparam logic [1:0] OPR = 2'b10;
  localparam logic [1:0] OPW = 2'b01;

  logic        mdc, rst_n, burst_en;
  logic        m_en, m_val, bus;
  logic        mdio_o, mdio_oe, rf_we;
  logic [4:0]  rf_addr;
  logic [15:0] rf_rdata, rf_wdata;

  logic [15:0] rf_mem  [0:31];
  logic [15:0] exp_mem [0:31];
  logic [15:0] got     [0:10];
  logic [15:0] wr_buf  [0:10];
  logic [4:0]  wr_alog [0:63];
  logic [15:0] wr_dlog [0:63];
  int          wr_cnt;
  logic        drv_seen, ta_ok, rel_ok;
  int          n_chk, n_bad;

  assign bus = mdio_oe ? mdio_o : (m_en ? m_val : 1'b1);

  mdio_burst_slave u_mdio_burst_slave (
    .mdc(mdc), .rst_n(rst_n), .mdio_i(bus), .phy_addr(MY_PHY),
    .burst_en(burst_en), .rf_rdata(rf_rdata), .mdio_o(mdio_o),
    .mdio_oe(mdio_oe), .rf_addr(rf_addr), .rf_we(rf_we), .rf_wdata(rf_wdata)
  );

  initial mdc = 1'b0;
  always #(CLK_PERIOD / 2) mdc = ~mdc;

  // register file model
  assign rf_rdata = rf_mem[rf_addr];
  always @(posedge mdc) if (rf_we) rf_mem[rf_addr] <= rf_wdata;

  // port monitor
  always @(posedge mdc) begin
    if (rst_n) begin
      if (rf_we && wr_cnt < 64) begin
        wr_alog[wr_cnt] = rf_addr;
        wr_dlog[wr_cnt] = rf_wdata;
        wr_cnt = wr_cnt + 1;
      end
      if (mdio_oe) drv_seen = 1'b1;
    end
  end

  function automatic logic [4:0] burst_addr(input int w);
    return (w < 6) ? 5'(w) : 5'(w + 10);
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send_bits(input logic [31:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      @(negedge mdc); m_en = 1'b1; m_val = v[i];
    end
  endtask

  task automatic run_frame(input logic [1:0] op, input logic [4:0] phy,
                           input logic [4:0] ra, input int nw, input int pre);
    drv_seen = 1'b0;
    for (int i = 0; i < pre; i++) begin
      @(negedge mdc); m_en = 1'b1; m_val = 1'b1;
    end
    send_bits({18'd0, 2'b01, op, phy, ra}, 14);
    if (op == OPR) begin
      @(negedge mdc); m_en = 1'b0;
      @(negedge mdc); ta_ok = (mdio_oe === 1'b1) && (bus === 1'b0);
      for (int w = 0; w < nw; w++)
        for (int j = 15; j >= 0; j--) begin
          @(negedge mdc); got[w][j] = bus;
        end
      @(negedge mdc); rel_ok = (mdio_oe === 1'b0); m_en = 1'b1; m_val = 1'b1;
    end else begin
      send_bits(32'd2, 2);
      for (int w = 0; w < nw; w++)
        for (int j = 15; j >= 0; j--) begin
          @(negedge mdc); m_val = wr_buf[w][j];
        end
      @(negedge mdc); m_val = 1'b1;
    end
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge mdc);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%0d expected=finish", WD_CYCLES);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    n_chk = 0; n_bad = 0; wr_cnt = 0; drv_seen = 1'b0;
    ta_ok = 1'b0; rel_ok = 1'b0;
    m_en = 1'b1; m_val = 1'b0; burst_en = 1'b0; rst_n = 1'b0;
    void'($urandom(32'd2024));
    for (int i = 0; i < 32; i++) begin
      rf_mem[i]  = 16'hC300 ^ 16'(i * 16'h0111);
      exp_mem[i] = 16'hC300 ^ 16'(i * 16'h0111);
    end
    repeat (4) @(negedge mdc);
    rst_n = 1'b1;
    @(negedge mdc);
    check("R1 oe after reset", 32'(mdio_oe), 32'd0);
    check("R1 we after reset", 32'(rf_we), 32'd0);

    // R2: too few idle ones before the first frame
    run_frame(OPR, MY_PHY, 5'd3, 1, 10);
    check("R2 short idle read not driven", 32'(drv_seen), 32'd0);

    // R5 then R4: directed write and readback
    wr_cnt = 0; wr_buf[0] = 16'h1234;
    run_frame(OPW, MY_PHY, 5'd3, 1, 34);
    exp_mem[3] = 16'h1234;
    check("R5 one strobe", 32'(wr_cnt), 32'd1);
    check("R5 strobe address", 32'(wr_alog[0]), 32'd3);
    check("R5 strobe data", 32'(wr_dlog[0]), 32'h1234);
    run_frame(OPR, MY_PHY, 5'd3, 1, 34);
    check("R4 turnaround zero", 32'(ta_ok), 32'd1);
    check("R4 read data", 32'(got[0]), 32'(exp_mem[3]));
    check("R7 single release", 32'(rel_ok), 32'd1);
    run_frame(OPR, MY_PHY, 5'd20, 1, 32);
    check("R4 read reg 20", 32'(got[0]), 32'(exp_mem[20]));

    // R3: foreign PHY and bad opcode
    wr_cnt = 0; wr_buf[0] = 16'h0F0F;
    run_frame(OPW, MY_PHY ^ 5'h01, 5'd2, 1, 34);
    check("R3 foreign write no strobe", 32'(wr_cnt), 32'd0);
    run_frame(OPR, 5'h15, 5'd2, 1, 34);
    check("R3 foreign read not driven", 32'(drv_seen), 32'd0);
    run_frame(2'b11, MY_PHY, 5'd2, 1, 34);
    check("R3 bad opcode no strobe", 32'(wr_cnt), 32'd0);
    run_frame(OPR, MY_PHY, 5'd2, 1, 34);
    check("R3 reg 2 untouched", 32'(got[0]), 32'(exp_mem[2]));

    // R9: reserved address with bursts off
    run_frame(OPR, MY_PHY, 5'd31, 1, 34);
    check("R9 reserved reads zero", 32'(got[0]), 32'd0);
    check("R9 reserved read drives", 32'(ta_ok), 32'd1);
    wr_cnt = 0; wr_buf[0] = 16'hFFFF;
    run_frame(OPW, MY_PHY, 5'd31, 1, 34);
    check("R9 reserved write ignored", 32'(wr_cnt), 32'd0);

    // R6 R8: burst write
    @(negedge mdc); burst_en = 1'b1;
    for (int w = 0; w < 11; w++) wr_buf[w] = 16'($urandom);
    wr_cnt = 0;
    run_frame(OPW, MY_PHY, 5'd31, 11, 34);
    check("R8 burst strobe count", 32'(wr_cnt), 32'd11);
    for (int w = 0; w < 11; w++) begin
      exp_mem[burst_addr(w)] = wr_buf[w];
      check("R8 burst write address", 32'(wr_alog[w]), 32'(burst_addr(w)));
      check("R8 burst write data", 32'(wr_dlog[w]), 32'(wr_buf[w]));
    end

    // R6 R7: burst read
    run_frame(OPR, MY_PHY, 5'd31, 11, 34);
    check("R7 burst turnaround", 32'(ta_ok), 32'd1);
    check("R7 burst release after 176 bits", 32'(rel_ok), 32'd1);
    for (int w = 0; w < 11; w++)
      check("R6 burst read word", 32'(got[w]), 32'(exp_mem[burst_addr(w)]));

    // R10: short idle after a frame
    run_frame(OPR, MY_PHY, 5'd3, 1, 20);
    check("R10 short gap not driven", 32'(drv_seen), 32'd0);
    run_frame(OPR, MY_PHY, 5'd3, 1, 32);
    check("R10 full idle accepted", 32'(got[0]), 32'(exp_mem[3]));

    // random single frames
    for (int k = 0; k < 40; k++) begin
      int idx;
      logic [4:0] a;
      idx = int'($urandom % 11);
      a = burst_addr(idx);
      if ($urandom % 2 == 0) begin
        wr_buf[0] = 16'($urandom);
        wr_cnt = 0;
        run_frame(OPW, MY_PHY, a, 1, 32 + int'($urandom % 8));
        exp_mem[a] = wr_buf[0];
        check("R5 random write strobe", 32'(wr_cnt), 32'd1);
      end else begin
        run_frame(OPR, MY_PHY, a, 1, 32 + int'($urandom % 8));
        check("R4 random read", 32'(got[0]), 32'(exp_mem[a]));
      end
    end

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule